// File: doc/BRIEF.md
# Touch Channel Baseline Tracker

This block keeps the baseline reference of one capacitive sensing channel. A periodic measurement strobe gives it the new signal sample, this channel's in-detect flag and a chip-wide flag that is high whenever any key is in detect. Between strobes nothing changes except the response to a host calibrate command or an all-key recalibration request.

The reference creeps toward the signal one count at a time. A count upward (the touch direction, signal above reference) needs a long run of strobes in that direction, and a count downward needs a shorter run. Drift is suspended on every channel while any key is touched and for a hold period after the last touch ends. Three events override drift and recalibrate: a sudden fall of the signal well below the reference, a detect that lasts past the programmed maximum, and a host command. A recalibration averages a fixed number of later samples into the reference. While it runs the calibrating flag is high, and when it starts the detection logic receives a one-cycle clear request. A maximum-duration timeout either recalibrates only this channel or raises an all-key request. The integration feeds that request back to every channel's global input.

Time is counted in units of `UNIT_STROBES` strobes. On the chip this is 20 strobes of 8 ms, or 160 ms. The bench uses shorter periods.

Top module: `ref_tracker`

## Requirements
- R1: After reset `calibrating_o` is 1, `ref_o` is 0, and `clear_det_o` and `all_cal_req_o` are 0. The first 2^`CAL_LOG2` strobes calibrate the reference.
- R2: A calibration raises `calibrating_o` and pulses `clear_det_o` for one cycle in the cycle after its start. It takes the samples of the next 2^`CAL_LOG2` strobes after the start and loads their floor average into `ref_o`, and `calibrating_o` falls together with that load.
- R3: With drift allowed, `TOWARD_UNITS*UNIT_STROBES` consecutive strobes with signal above reference raise `ref_o` by exactly one, and no earlier.
- R4: With drift allowed, `AWAY_UNITS*UNIT_STROBES` consecutive strobes with signal below reference, but not more than `JUMP_LIMIT` below it, lower `ref_o` by exactly one.
- R5: A strobe whose direction is opposite to the previous counted strobe restarts both direction counts, so a full period is needed again.
- R6: Drift is held on every strobe with `any_detect_i` high and on the next `HOLD_UNITS*UNIT_STROBES` strobes after it falls. Held strobes restart both direction counts.
- R7: A strobe with `ref_o - signal_i` greater than `JUMP_LIMIT` starts a calibration. A difference of exactly `JUMP_LIMIT` does not.
- R8: With `max_on_i` = N > 0, the (N*`UNIT_STROBES`)-th consecutive strobe with `in_detect_i` high times out. If `max_cal_single_i` is 1, this channel alone recalibrates and `all_cal_req_o` stays 0.
- R9: If `max_cal_single_i` is 0, a timeout instead pulses `all_cal_req_o` for one cycle after the timeout strobe. A high `global_cal_i` starts a calibration at the next edge.
- R10: With `max_on_i` = 0, no length of detect causes a timeout.
- R11: A one-cycle `cal_cmd_i` starts a calibration at the next edge, whatever the signal and detect state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | One-cycle measurement strobe |
| signal_i | input | SIG_W | Signal sample, valid with the strobe |
| in_detect_i | input | 1 | This channel is in detect |
| any_detect_i | input | 1 | Some channel is in detect |
| max_on_i | input | MAXON_W | Maximum detect duration in units, 0 disables |
| max_cal_single_i | input | 1 | 1: timeout recalibrates this channel only |
| cal_cmd_i | input | 1 | Host calibrate command |
| global_cal_i | input | 1 | All-key recalibration from the chip |
| ref_o | output | SIG_W | Baseline reference |
| calibrating_o | output | 1 | Calibration in progress |
| clear_det_o | output | 1 | One-cycle request to clear detect status |
| all_cal_req_o | output | 1 | One-cycle request to recalibrate all keys |

## Verification
The assertions assume that `in_detect_i` is high only while `any_detect_i` is also high. They assume that `global_cal_i` comes from the chip's all-key request path and not from an independent source. They also assume that `signal_i` is only meaningful on strobe cycles. The stimulus raises `in_detect_i` only together with `any_detect_i` and ties `global_cal_i` to the block's own `all_cal_req_o`. It spaces strobes one idle cycle apart and changes inputs away from the clock edge. Signal steps are chosen so that each drift run stays within `JUMP_LIMIT`, except when a jump is the intended stimulus.

// File: rtl/ref_trk_pkg.sv
package ref_trk_pkg;
  typedef enum logic [1:0] {
    DIR_NONE = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DOWN = 2'd2
  } drift_dir_e;
endpackage

// File: rtl/ref_drift.sv
module ref_drift
  import ref_trk_pkg::*;
#(
  parameter int SIG_W  = 16,
  parameter int UP_PER = 360,
  parameter int DN_PER = 120
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strobe_i,
  input  logic             clear_i,
  input  logic [SIG_W-1:0] sig_i,
  input  logic [SIG_W-1:0] ref_i,
  output logic             step_up_o,
  output logic             step_dn_o
);
  localparam int UP_W = $clog2(UP_PER + 1);
  localparam int DN_W = $clog2(DN_PER + 1);

  logic [UP_W-1:0] up_cnt_q;
  logic [DN_W-1:0] dn_cnt_q;
  drift_dir_e      dir;
  logic            up_wrap, dn_wrap;

  always_comb begin
    if (sig_i > ref_i)      dir = DIR_UP;
    else if (sig_i < ref_i) dir = DIR_DOWN;
    else                    dir = DIR_NONE;
  end

  assign up_wrap   = (up_cnt_q == UP_W'(UP_PER - 1));
  assign dn_wrap   = (dn_cnt_q == DN_W'(DN_PER - 1));
  assign step_up_o = strobe_i && !clear_i && (dir == DIR_UP) && up_wrap;
  assign step_dn_o = strobe_i && !clear_i && (dir == DIR_DOWN) && dn_wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_cnt_q <= '0;
      dn_cnt_q <= '0;
    end else if (strobe_i) begin
      if (clear_i) begin
        up_cnt_q <= '0;
        dn_cnt_q <= '0;
      end else begin
        unique case (dir)
          DIR_UP: begin
            dn_cnt_q <= '0;
            up_cnt_q <= up_wrap ? '0 : up_cnt_q + UP_W'(1);
          end
          DIR_DOWN: begin
            up_cnt_q <= '0;
            dn_cnt_q <= dn_wrap ? '0 : dn_cnt_q + DN_W'(1);
          end
          default: ;
        endcase
      end
    end
  end

  // R5
  one_dir_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_cnt_q != '0) |-> (dn_cnt_q == '0));
endmodule

// File: rtl/ref_timers.sv
module ref_timers #(
  parameter int UNIT_STROBES = 20,
  parameter int HOLD_STROBES = 500,
  parameter int MAXON_W      = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               strobe_i,
  input  logic               clear_i,
  input  logic               any_detect_i,
  input  logic               in_detect_i,
  input  logic [MAXON_W-1:0] max_on_i,
  output logic               hold_o,
  output logic               timeout_o
);
  localparam int HOLD_W = $clog2(HOLD_STROBES + 1);
  localparam int ON_W   = MAXON_W + $clog2(UNIT_STROBES + 1);

  logic [HOLD_W-1:0] hold_cnt_q;
  logic [ON_W-1:0]   on_cnt_q;
  logic [ON_W-1:0]   on_limit;
  logic              on_run, on_hit;

  assign hold_o = any_detect_i || (hold_cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_cnt_q <= '0;
    else if (strobe_i) begin
      if (any_detect_i)           hold_cnt_q <= HOLD_W'(HOLD_STROBES);
      else if (hold_cnt_q != '0)  hold_cnt_q <= hold_cnt_q - HOLD_W'(1);
    end
  end

  // Duration limit in strobes; max_on_i of zero disables.
  assign on_limit  = ON_W'(max_on_i) * ON_W'(UNIT_STROBES);
  assign on_run    = in_detect_i && (max_on_i != '0) && !clear_i;
  assign on_hit    = (on_cnt_q == on_limit - ON_W'(1));
  assign timeout_o = strobe_i && on_run && on_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) on_cnt_q <= '0;
    else if (strobe_i) begin
      if (!on_run || on_hit) on_cnt_q <= '0;
      else                   on_cnt_q <= on_cnt_q + ON_W'(1);
    end
  end

  // R10
  no_timeout_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> (max_on_i != '0) && in_detect_i);
  // R6
  hold_after_touch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && any_detect_i) |=> hold_o);
endmodule

// File: rtl/ref_cal.sv
module ref_cal #(
  parameter int SIG_W    = 16,
  parameter int CAL_LOG2 = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strobe_i,
  input  logic             start_i,
  input  logic [SIG_W-1:0] sig_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [SIG_W-1:0] avg_o
);
  localparam int CAL_N = 1 << CAL_LOG2;
  localparam int CNT_W = (CAL_LOG2 > 0) ? CAL_LOG2 : 1;
  localparam int SUM_W = SIG_W + CAL_LOG2;

  logic [CNT_W-1:0] cnt_q;
  logic [SUM_W-1:0] sum_q, sum_full;
  logic             last;

  assign last     = (cnt_q == CNT_W'(CAL_N - 1));
  assign done_o   = strobe_i && busy_o && last && !start_i;
  assign sum_full = sum_q + SUM_W'(sig_i);
  assign avg_o    = sum_full[SUM_W-1 -: SIG_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b1;
      cnt_q  <= '0;
      sum_q  <= '0;
    end else if (start_i) begin
      busy_o <= 1'b1;
      cnt_q  <= '0;
      sum_q  <= '0;
    end else if (strobe_i && busy_o) begin
      if (last) begin
        busy_o <= 1'b0;
        cnt_q  <= '0;
        sum_q  <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
        sum_q <= sum_full;
      end
    end
  end

  // R2
  busy_until_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !strobe_i) |=> busy_o);
  // R2
  done_releases_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
endmodule

// File: rtl/ref_tracker.sv
module ref_tracker #(
  parameter int SIG_W        = 16,
  parameter int UNIT_STROBES = 20,
  parameter int TOWARD_UNITS = 18,
  parameter int AWAY_UNITS   = 6,
  parameter int HOLD_UNITS   = 25,
  parameter int JUMP_LIMIT   = 4,
  parameter int CAL_LOG2     = 1,
  parameter int MAXON_W      = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               strobe_i,
  input  logic [SIG_W-1:0]   signal_i,
  input  logic               in_detect_i,
  input  logic               any_detect_i,
  input  logic [MAXON_W-1:0] max_on_i,
  input  logic               max_cal_single_i,
  input  logic               cal_cmd_i,
  input  logic               global_cal_i,
  output logic [SIG_W-1:0]   ref_o,
  output logic               calibrating_o,
  output logic               clear_det_o,
  output logic               all_cal_req_o
);
  localparam int UP_PER       = TOWARD_UNITS * UNIT_STROBES;
  localparam int DN_PER       = AWAY_UNITS * UNIT_STROBES;
  localparam int HOLD_STROBES = HOLD_UNITS * UNIT_STROBES;
  localparam logic [SIG_W-1:0] REF_MAX = '1;

  logic [SIG_W-1:0] ref_q, avg;
  logic             busy, cal_done, hold, timeout;
  logic             jump, local_trig, cal_start, drift_clear;
  logic             step_up, step_dn;
  logic             clr_q, all_q;

  assign jump = (ref_q > signal_i) && ((ref_q - signal_i) > SIG_W'(JUMP_LIMIT));
  assign local_trig  = strobe_i && !busy && (jump || (timeout && max_cal_single_i));
  assign cal_start   = cal_cmd_i || global_cal_i || local_trig;
  assign drift_clear = busy || cal_start || hold;

  ref_timers #(
    .UNIT_STROBES(UNIT_STROBES),
    .HOLD_STROBES(HOLD_STROBES),
    .MAXON_W     (MAXON_W)
  ) u_timers (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .strobe_i    (strobe_i),
    .clear_i     (busy),
    .any_detect_i(any_detect_i),
    .in_detect_i (in_detect_i),
    .max_on_i    (max_on_i),
    .hold_o      (hold),
    .timeout_o   (timeout)
  );

  ref_drift #(
    .SIG_W (SIG_W),
    .UP_PER(UP_PER),
    .DN_PER(DN_PER)
  ) u_drift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (strobe_i),
    .clear_i  (drift_clear),
    .sig_i    (signal_i),
    .ref_i    (ref_q),
    .step_up_o(step_up),
    .step_dn_o(step_dn)
  );

  ref_cal #(
    .SIG_W   (SIG_W),
    .CAL_LOG2(CAL_LOG2)
  ) u_cal (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strobe_i(strobe_i),
    .start_i (cal_start),
    .sig_i   (signal_i),
    .busy_o  (busy),
    .done_o  (cal_done),
    .avg_o   (avg)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ref_q <= '0;
    else if (cal_done)                   ref_q <= avg;
    else if (step_up && ref_q != REF_MAX) ref_q <= ref_q + SIG_W'(1);
    else if (step_dn && ref_q != '0)      ref_q <= ref_q - SIG_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clr_q <= 1'b0;
      all_q <= 1'b0;
    end else begin
      clr_q <= cal_start;
      all_q <= strobe_i && !busy && timeout && !max_cal_single_i;
    end
  end

  assign ref_o         = ref_q;
  assign calibrating_o = busy;
  assign clear_det_o   = clr_q;
  assign all_cal_req_o = all_q;

  // R3
  slow_slew_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cal_done |=> (ref_q == $past(ref_q) || ref_q == $past(ref_q) + SIG_W'(1) ||
                   ref_q == $past(ref_q) - SIG_W'(1)));
  // R6
  held_no_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && hold) |-> !step_up && !step_dn);
  // R7
  jump_recal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && !calibrating_o && ref_o > signal_i &&
     (ref_o - signal_i) > SIG_W'(JUMP_LIMIT)) |=> calibrating_o);
  // R2
  clear_with_cal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_det_o |-> calibrating_o);
  // R9
  all_req_scope_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    all_cal_req_o |-> $past(!max_cal_single_i));
  // R11
  cmd_starts_cal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_cmd_i |=> calibrating_o);
endmodule

// File: tb/tb_ref_tracker.sv
`timescale 1ns/1ps
module tb_ref_tracker;
  localparam int SIG_W = 16;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             strobe = 1'b0;
  logic [SIG_W-1:0] sig = '0;
  logic             in_det = 1'b0, any_det = 1'b0;
  logic [7:0]       max_on = '0;
  logic             single = 1'b1, cmd = 1'b0;
  logic [SIG_W-1:0] ref_v;
  logic             cal, clr, all_req;

  always #10 clk = ~clk;

  ref_tracker #(
    .SIG_W(SIG_W), .UNIT_STROBES(2), .TOWARD_UNITS(3), .AWAY_UNITS(2),
    .HOLD_UNITS(2), .JUMP_LIMIT(4), .CAL_LOG2(1), .MAXON_W(8)
  ) dut (
    .clk_i(clk), .rst_ni(rst_ni), .strobe_i(strobe), .signal_i(sig),
    .in_detect_i(in_det), .any_detect_i(any_det), .max_on_i(max_on),
    .max_cal_single_i(single), .cal_cmd_i(cmd), .global_cal_i(all_req),
    .ref_o(ref_v), .calibrating_o(cal), .clear_det_o(clr), .all_cal_req_o(all_req)
  );

  typedef struct {
    string tag;
    int    kind;
    int    exp;
  } item_t;

  item_t q[$];
  item_t it;
  int    checks = 0, errors = 0;
  bit    done = 1'b0;

  localparam int K_REF = 0, K_CAL = 1, K_CLR = 2, K_ALL = 3;

  task automatic expect_v(input string tag, input int kind, input int exp);
    item_t x;
    x.tag = tag; x.kind = kind; x.exp = exp;
    q.push_back(x);
  endtask

  always @(negedge clk) begin
    while (q.size() > 0) begin
      int got;
      it = q.pop_front();
      case (it.kind)
        K_REF:   got = int'(ref_v);
        K_CAL:   got = int'(cal);
        K_CLR:   got = int'(clr);
        default: got = int'(all_req);
      endcase
      checks++;
      if (got != it.exp) begin
        errors++;
        $display("FAIL %s kind=%0d actual=%0d expected=%0d", it.tag, it.kind, got, it.exp);
      end
    end
  end

  task automatic do_strobe(input int s, input bit ind, input bit anyd);
    @(posedge clk); #1;
    strobe = 1'b1; sig = SIG_W'(s); in_det = ind; any_det = anyd;
    @(posedge clk); #1;
    strobe = 1'b0;
  endtask

  task automatic idle();
    @(posedge clk); #1;
  endtask

  task automatic finish_run();
    @(negedge clk); #1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    idle();
    expect_v("R1 reset cal", K_CAL, 1);
    expect_v("R1 reset ref", K_REF, 0);
    expect_v("R1 reset clr", K_CLR, 0);
    expect_v("R1 reset all", K_ALL, 0);

    // R1/R2 initial calibration over two samples
    do_strobe(100, 0, 0);
    expect_v("R2 cal mid", K_CAL, 1);
    do_strobe(102, 0, 0);
    expect_v("R2 avg", K_REF, 101);
    expect_v("R2 released", K_CAL, 0);

    // R3: six strobes above raise by one
    for (int i = 0; i < 5; i++) do_strobe(105, 0, 0);
    expect_v("R3 not early", K_REF, 101);
    do_strobe(105, 0, 0);
    expect_v("R3 step", K_REF, 102);

    // R5: reversal restarts counts
    for (int i = 0; i < 3; i++) do_strobe(105, 0, 0);
    for (int i = 0; i < 3; i++) do_strobe(100, 0, 0);
    for (int i = 0; i < 5; i++) do_strobe(105, 0, 0);
    expect_v("R5 restart", K_REF, 102);
    do_strobe(105, 0, 0);
    expect_v("R5 full period", K_REF, 103);

    // R4: four strobes below lower by one
    for (int i = 0; i < 3; i++) do_strobe(100, 0, 0);
    expect_v("R4 not early", K_REF, 103);
    do_strobe(100, 0, 0);
    expect_v("R4 step", K_REF, 102);

    // R6: hold during touch and four strobes after
    for (int i = 0; i < 10; i++) do_strobe(110, 0, 1);
    expect_v("R6 held touch", K_REF, 102);
    for (int i = 0; i < 9; i++) do_strobe(110, 0, 0);
    expect_v("R6 held after", K_REF, 102);
    do_strobe(110, 0, 0);
    expect_v("R6 resumes", K_REF, 103);

    // R7: boundary then jump
    do_strobe(99, 0, 0);
    expect_v("R7 boundary no cal", K_CAL, 0);
    do_strobe(98, 0, 0);
    expect_v("R7 jump cal", K_CAL, 1);
    expect_v("R7 clear pulse", K_CLR, 1);
    idle();
    expect_v("R2 clear one cycle", K_CLR, 0);
    do_strobe(90, 0, 0);
    do_strobe(94, 0, 0);
    expect_v("R7 recal ref", K_REF, 92);

    // R8: single-key timeout, max_on=2 -> 4 strobes
    max_on = 8'd2; single = 1'b1;
    for (int i = 0; i < 3; i++) do_strobe(120, 1, 1);
    expect_v("R8 not early", K_CAL, 0);
    do_strobe(120, 1, 1);
    expect_v("R8 timeout cal", K_CAL, 1);
    expect_v("R8 no all req", K_ALL, 0);
    do_strobe(120, 0, 0);
    do_strobe(122, 0, 0);
    expect_v("R8 recal ref", K_REF, 121);

    // R9: all-key scope
    single = 1'b0;
    for (int i = 0; i < 3; i++) do_strobe(130, 1, 1);
    do_strobe(130, 1, 1);
    in_det = 1'b0;
    expect_v("R9 all req", K_ALL, 1);
    expect_v("R9 not yet cal", K_CAL, 0);
    idle();
    expect_v("R9 global cal", K_CAL, 1);
    expect_v("R9 req one cycle", K_ALL, 0);
    do_strobe(130, 0, 0);
    do_strobe(132, 0, 0);
    expect_v("R9 recal ref", K_REF, 131);

    // R10: disabled timeout
    max_on = 8'd0;
    for (int i = 0; i < 10; i++) do_strobe(140, 1, 1);
    expect_v("R10 no cal", K_CAL, 0);
    expect_v("R10 ref kept", K_REF, 131);
    expect_v("R10 no all req", K_ALL, 0);

    // R11: host command
    in_det = 1'b0; any_det = 1'b0;
    @(posedge clk); #1 cmd = 1'b1;
    @(posedge clk); #1 cmd = 1'b0;
    expect_v("R11 cmd cal", K_CAL, 1);
    expect_v("R11 cmd clear", K_CLR, 1);
    do_strobe(136, 0, 0);
    do_strobe(139, 0, 0);
    expect_v("R11 recal ref", K_REF, 137);
    expect_v("R11 released", K_CAL, 0);

    done = 1'b1;
    finish_run();
  end
endmodule